// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block produces the digital reference code for a step-down regulator. The analog converter downstream of it turns that code into a voltage. The block waits until both supply monitors report good and the enable pin is high. It then works out a target setpoint from two three-level select inputs and an optional margin request. Starting from zero, it moves the code toward that target by exactly one code per microsecond tick, and one code is 2.5 mV.

When the code arrives at the target, the block raises power-good. From then on it follows the live select and margin inputs. Any new target is approached at the same one-code-per-tick rate, and power-good stays high while it moves.

If either supply monitor drops, or the enable pin goes low, power-good falls at once and the code returns to zero. When supplies and enable are valid again, a fresh soft-start begins. The block has no streaming data path: every port is a plain level.

Top module: `vref_ramp_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `ref_code` is 0 and `pgood` is 0.
- R2: With either supply-good input low, enable and select activity have no effect: `ref_code` stays 0 and `pgood` stays 0.
- R3: Each select uses the 2-bit encoding 00 = low, 01 = float, 10 = high. The setpoint index is 3 × major + minor, where low = 0, float = 1 and high = 2. Indices 0 to 8 give codes 240, 300, 360, 400, 420, 440, 480, 600 and 720.
- R4: A select encoding of 11 decodes the same as float (01).
- R5: The start edge is the first edge at which both supplies are good and enable is high. After it, the code rises by exactly 1 every `TICK_CYC` clock cycles. The first step comes `TICK_CYC` cycles after the start edge. The code never passes the target.
- R6: `pgood` rises on the same clock edge on which `ref_code` first equals the target, and never earlier.
- R7: The target used during start-up is captured at the start edge. Changes to the select or margin inputs during the ramp do not change the final code.
- R8: `mrg_mode` uses 00 or 11 = none, 01 = up, 10 = down. The margin size is floor(base × P / 100), where P is `MRG_PCT_NARROW` when `mrg_wide` is 0 and `MRG_PCT_WIDE` when it is 1. After power-good, a new target is reached one code per tick, in either direction, with `pgood` held high.
- R9: When either supply-good input or enable is low, `pgood` is 0 in that same cycle, combinationally. `ref_code` is 0 after the next clock edge.
- R10: When supplies and enable are valid again after a drop, a fresh soft-start runs from code 0 using the inputs sampled at the new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| logic_sup_ok | input | 1 | Logic supply above its power-on threshold |
| power_sup_ok | input | 1 | Power-stage supply above its power-on threshold |
| en | input | 1 | Regulator enable |
| sel_major | input | 2 | Three-level select, major digit (00 low, 01 float, 10 high, 11 float) |
| sel_minor | input | 2 | Three-level select, minor digit (same encoding) |
| mrg_mode | input | 2 | Margin request: 01 up, 10 down, otherwise none |
| mrg_wide | input | 1 | Margin size: 0 narrow percentage, 1 wide percentage |
| ref_code | output | 10 | Reference code, 2.5 mV per LSB |
| pgood | output | 1 | Power-good flag |

## Verification
The hardest situation to reach from the ports is a target change after power-good: the setpoint must move while the ramp is complete and must not disturb `pgood`. The stimulus first runs a full soft-start to power-good. It then toggles the margin controls in both directions while the behavioural model follows the code tick by tick. A second case changes the selects part-way through a ramp, to show that the captured target wins until power-good.

// File: rtl/vref_ramp_pkg.sv
package vref_ramp_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RAMP = 2'd1,
    ST_HOLD = 2'd2
  } ramp_st_e;

  // Map a 2-bit three-level encoding to a digit 0..2; 11 reads as float.
  function automatic logic [1:0] tri_digit(input logic [1:0] enc);
    case (enc)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Setpoint codes in 2.5 mV units, indexed by 3*major+minor.
  function automatic logic [9:0] base_code(input logic [3:0] idx);
    case (idx)
      4'd0:    return 10'd240;
      4'd1:    return 10'd300;
      4'd2:    return 10'd360;
      4'd3:    return 10'd400;
      4'd4:    return 10'd420;
      4'd5:    return 10'd440;
      4'd6:    return 10'd480;
      4'd7:    return 10'd600;
      default: return 10'd720;
    endcase
  endfunction

endpackage

// File: rtl/vref_target.sv
module vref_target #(
  parameter int CODE_W     = 10,
  parameter int PCT_NARROW = 5,
  parameter int PCT_WIDE   = 10
) (
  input  logic [1:0]        sel_major,
  input  logic [1:0]        sel_minor,
  input  logic [1:0]        mrg_mode,
  input  logic              mrg_wide,
  output logic [CODE_W-1:0] tgt
);
  import vref_ramp_pkg::*;

  localparam int PROD_W = CODE_W + 8;
  localparam logic [PROD_W-1:0] PN   = PROD_W'(PCT_NARROW);
  localparam logic [PROD_W-1:0] PW   = PROD_W'(PCT_WIDE);
  localparam logic [PROD_W-1:0] MAXC = PROD_W'((1 << CODE_W) - 1);

  logic [3:0]        idx;
  logic [PROD_W-1:0] base, prod, delta, sum;

  always_comb begin
    idx   = {2'b00, tri_digit(sel_major)} * 4'd3 + {2'b00, tri_digit(sel_minor)};
    base  = PROD_W'(base_code(idx));
    prod  = base * (mrg_wide ? PW : PN);
    delta = prod / PROD_W'(100);
    case (mrg_mode)
      2'b01:   sum = base + delta;
      2'b10:   sum = (delta > base) ? '0 : base - delta;
      default: sum = base;
    endcase
    if (sum > MAXC) sum = MAXC;
    tgt = sum[CODE_W-1:0];
  end

endmodule

// File: rtl/vref_tick.sv
module vref_tick #(
  parameter int TICK_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/vref_slew.sv
module vref_slew #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] live_tgt,
  output logic [CODE_W-1:0] code,
  output logic              hold,
  output logic              off
);
  import vref_ramp_pkg::*;

  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  ramp_st_e          st;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] up, dn;

  assign up   = code + ONE;
  assign dn   = code - ONE;
  assign hold = (st == ST_HOLD);
  assign off  = (st == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      code  <= '0;
      tgt_q <= '0;
    end else if (!run) begin
      st    <= ST_OFF;
      code  <= '0;
      tgt_q <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          tgt_q <= live_tgt;
          st    <= ST_RAMP;
        end
        ST_RAMP: begin
          if (code == tgt_q) begin
            st <= ST_HOLD;
          end else if (tick) begin
            code <= up;
            if (up == tgt_q) st <= ST_HOLD;
          end
        end
        default: begin
          tgt_q <= live_tgt;
          if (tick) begin
            if (code < tgt_q)      code <= up;
            else if (code > tgt_q) code <= dn;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vref_ramp_ctrl.sv
module vref_ramp_ctrl #(
  parameter int CODE_W         = 10,
  parameter int TICK_CYC       = 100,
  parameter int MRG_PCT_NARROW = 5,
  parameter int MRG_PCT_WIDE   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              logic_sup_ok,
  input  logic              power_sup_ok,
  input  logic              en,
  input  logic [1:0]        sel_major,
  input  logic [1:0]        sel_minor,
  input  logic [1:0]        mrg_mode,
  input  logic              mrg_wide,
  output logic [CODE_W-1:0] ref_code,
  output logic              pgood
);
  logic              run, tick, hold, off;
  logic [CODE_W-1:0] live_tgt;

  assign run = logic_sup_ok && power_sup_ok && en;

  vref_target #(
    .CODE_W(CODE_W), .PCT_NARROW(MRG_PCT_NARROW), .PCT_WIDE(MRG_PCT_WIDE)
  ) u_target (
    .sel_major(sel_major), .sel_minor(sel_minor),
    .mrg_mode(mrg_mode), .mrg_wide(mrg_wide), .tgt(live_tgt)
  );

  vref_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(off), .tick(tick)
  );

  vref_slew #(.CODE_W(CODE_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .live_tgt(live_tgt),
    .code(ref_code), .hold(hold), .off(off)
  );

  assign pgood = hold && run;

endmodule

// File: rtl/vref_ramp_chk.sv
module vref_ramp_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              logic_sup_ok,
  input logic              power_sup_ok,
  input logic              en,
  input logic [CODE_W-1:0] ref_code,
  input logic              pgood
);
  logic run_c;
  assign run_c = logic_sup_ok && power_sup_ok && en;

  assert_pg_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_c |-> !pgood);

  assert_code_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_c |=> (ref_code == '0));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_c |=> (ref_code == $past(ref_code) ||
               ref_code == $past(ref_code) + CODE_W'(1) ||
               ref_code == $past(ref_code) - CODE_W'(1)));

  assert_pg_on_arrival_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> (ref_code != $past(ref_code)));

  assert_zero_not_good_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code == '0) |-> !pgood);

endmodule

bind vref_ramp_ctrl vref_ramp_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .logic_sup_ok(logic_sup_ok),
  .power_sup_ok(power_sup_ok), .en(en), .ref_code(ref_code), .pgood(pgood)
);

// File: tb/vref_ramp_ctrl_bench.sv
module vref_ramp_ctrl_bench;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sa = 1'b0, sb = 1'b0, en = 1'b0;
  logic [1:0] smaj = 2'b00, smin = 2'b00, mmode = 2'b00;
  logic       mwide = 1'b0;
  logic [9:0] code;
  logic       pg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vref_ramp_ctrl #(.TICK_CYC(N)) u_vref_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .logic_sup_ok(sa), .power_sup_ok(sb), .en(en),
    .sel_major(smaj), .sel_minor(smin), .mrg_mode(mmode), .mrg_wide(mwide),
    .ref_code(code), .pgood(pg)
  );

  function automatic int dig(input logic [1:0] e);
    if (e == 2'b00) return 0;
    if (e == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int calc_tgt(input logic [1:0] ma, input logic [1:0] mi,
                                  input logic [1:0] mm, input logic w);
    int mv[9] = '{600, 750, 900, 1000, 1050, 1100, 1200, 1500, 1800};
    int b, d;
    b = mv[dig(ma) * 3 + dig(mi)] * 2 / 5;
    d = b * (w ? 10 : 5) / 100;
    if (mm == 2'b01) return b + d;
    if (mm == 2'b10) return b - d;
    return b;
  endfunction

  // behavioural reference model
  int m_st = 0, m_code = 0, m_tgt = 0, m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n || !(sa && sb && en)) begin
      m_st = 0; m_code = 0; m_tgt = 0; m_cnt = 0;
    end else if (m_st == 0) begin
      m_tgt = calc_tgt(smaj, smin, mmode, mwide); m_st = 1; m_cnt = 0;
    end else begin
      if (m_cnt == N - 1) begin
        m_cnt = 0;
        if (m_code < m_tgt) m_code++;
        else if (m_code > m_tgt && m_st == 2) m_code--;
        if (m_st == 1 && m_code == m_tgt) m_st = 2;
      end else m_cnt++;
      if (m_st == 2) m_tgt = calc_tgt(smaj, smin, mmode, mwide);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 model code", int'(code), m_code);
      chk("R6 model pgood", int'(pg), int'(m_st == 2 && sa && sb && en));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wait_pg(output int cnt);
    cnt = 0;
    while (!pg && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic ramp(input logic [1:0] ma, input logic [1:0] mi, input int exp,
                      input string req);
    int c;
    en = 1'b0; step(3);
    smaj = ma; smin = mi;
    en = 1'b1;
    wait_pg(c);
    chk({req, " final code"}, int'(code), exp);
    chk("R5 ramp time", c, exp * N + 2);
    step(1);
  endtask

  initial begin
    int c;
    int pg_low;
    step(5);
    chk("R1 reset code", int'(code), 0);
    chk("R1 reset pgood", int'(pg), 0);
    rst_n = 1'b1; step(3);
    @(negedge clk);
    chk("R1 idle code", int'(code), 0);
    step(1);

    // R2: enable with one supply missing
    sa = 1'b1; sb = 1'b0; en = 1'b1; smaj = 2'b10; smin = 2'b10;
    step(40);
    @(negedge clk);
    chk("R2 code held", int'(code), 0);
    chk("R2 pgood held", int'(pg), 0);
    step(1);
    sb = 1'b1;

    ramp(2'b00, 2'b00, 240, "R3 idx0");
    ramp(2'b11, 2'b10, 440, "R4 float-11");
    ramp(2'b10, 2'b10, 720, "R3 idx8");

    // R7: change selects part-way through a ramp
    en = 1'b0; step(3);
    smaj = 2'b01; smin = 2'b00; en = 1'b1;
    step(100);
    smaj = 2'b10; smin = 2'b10; mmode = 2'b01;
    wait_pg(c);
    chk("R7 captured target", int'(code), 400);
    smaj = 2'b01; smin = 2'b00; mmode = 2'b00;
    step(2);

    // R8: margin moves after power-good
    mmode = 2'b01; mwide = 1'b0;
    pg_low = 0;
    repeat (20 * N + 6) begin @(negedge clk); if (!pg) pg_low++; end
    chk("R8 margin up code", int'(code), 420);
    chk("R8 pgood kept up", pg_low, 0);
    step(1);
    mmode = 2'b10; mwide = 1'b1;
    pg_low = 0;
    repeat (60 * N + 6) begin @(negedge clk); if (!pg) pg_low++; end
    chk("R8 margin down code", int'(code), 360);
    chk("R8 pgood kept down", pg_low, 0);
    step(1);

    // R9: enable drop
    en = 1'b0;
    @(negedge clk);
    chk("R9 pgood same cycle", int'(pg), 0);
    @(negedge clk);
    chk("R9 code cleared", int'(code), 0);
    step(1);

    // R10: restart from zero with the margin-down target
    en = 1'b1;
    repeat (N) @(negedge clk);
    chk("R10 restart at zero", int'(code), 0);
    wait_pg(c);
    chk("R10 restart target", int'(code), 360);
    step(1);

    // R9: supply drop
    sb = 1'b0;
    @(negedge clk);
    chk("R9 supply pgood", int'(pg), 0);
    @(negedge clk);
    chk("R9 supply code", int'(code), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule